// File: doc/BRIEF.md
# Programmable Divider Pulse Timer

This block makes a square wave with a programmable period. A free-running prescaler divides the system clock. One of three of its taps is chosen by a 2-bit select, and that tap gives a single-cycle count-enable pulse. On each enable, an 8-bit up-counter is compared with a compare register that software writes. When the two are equal, the counter returns to zero and an output flip-flop changes state. Each half period of the wave therefore lasts (compare + 1) count periods, and the duty cycle is close to 50%.

The output pin carries the inverse of the flip-flop. Every toggle raises a one-cycle interrupt strobe. Software can force the flip-flop to a chosen level at any time. A run control gates the counter, and select code 11 stops counting. The whole block runs on the single system clock.

Top module: `pdo_pulse_timer`

## Requirements
- R1: After reset the flip-flop is 0, so `pin_out` is 1 and `irq` is 0.
- R2: With run high, consecutive toggles are exactly (C+1)·2^k system cycles apart. C is the compare value and k is the tap exponent: select 00 → k=TAP_SLOW (default 11, 2048 cycles), 01 → TAP_MID (default 7, 128), 10 → TAP_FAST (default 3, 8).
- R3: `pin_out` is always the inverse of the flip-flop. Each toggle inverts `pin_out`, and `irq` is high in exactly the first cycle in which the new `pin_out` value is visible.
- R4: `irq` is a single-cycle pulse. It is never high in two consecutive cycles.
- R5: A compare value of 0 gives a match on every count-enable, so the output toggles once per count period.
- R6: Select code 11 gives no count-enables. With run high, no toggle and no `irq` occur, and `pin_out` holds its value.
- R7: While `run` is low the counter is held at zero, and no toggle or `irq` occurs. After `run` rises, the first toggle comes between C·2^k+1 and (C+1)·2^k cycles later, depending on the prescaler phase.
- R8: A flip-flop write (`ff_wr`=1) sets the flip-flop to `ff_wdata`, so `pin_out` = not `ff_wdata` from the next cycle. The write raises no `irq`. A write wins over a toggle in the same cycle: the toggle and its `irq` are dropped, but the counter still clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_sel | input | 2 | Count-clock tap select (00 slow, 01 mid, 10 fast, 11 stopped) |
| run | input | 1 | Counting enable; the counter is held at zero when low |
| cmp_wr | input | 1 | Compare register write strobe |
| cmp_wdata | input | CNT_W | Compare register write value |
| ff_wr | input | 1 | Output flip-flop write strobe |
| ff_wdata | input | 1 | Value written into the output flip-flop |
| pin_out | output | 1 | Inverted output flip-flop |
| irq | output | 1 | One-cycle strobe on every toggle |

## Verification
The bench builds the timer with tap exponents of 6, 4 and 2 (64, 16 and 4 cycles) in place of 11, 7 and 3. With these values every select code and several compare values, including 0 and 0x5F, fit in a short run, and the exact toggle spacing can be measured for each tap. The 4-cycle tap with compare 0 makes the toggle edge predictable. This lets the bench land a software write on the same edge as a toggle and check which one wins.

// File: rtl/pdo_pkg.sv
package pdo_pkg;

    typedef enum logic [1:0] {
        SEL_SLOW = 2'b00,
        SEL_MID  = 2'b01,
        SEL_FAST = 2'b10,
        SEL_OFF  = 2'b11
    } clk_sel_e;

    localparam int NUM_TAPS = 3;

    // Event passed from the counter to the output stage
    typedef struct packed {
        logic en;     // count-enable seen this cycle
        logic hit;    // counter equals compare on that enable
    } cnt_evt_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    // Map a select code to its tap index; NUM_TAPS means no tap
    function automatic int sel_to_tap(input clk_sel_e s);
        case (s)
            SEL_SLOW: return 0;
            SEL_MID:  return 1;
            SEL_FAST: return 2;
            default:  return NUM_TAPS;
        endcase
    endfunction

endpackage

// File: rtl/pdo_prescaler.sv
module pdo_prescaler
    import pdo_pkg::*;
#(
    parameter int TAP_SLOW = 11,
    parameter int TAP_MID  = 7,
    parameter int TAP_FAST = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  clk_sel_e   sel,
    output logic       en_o
);
    localparam int PRE_W = max3(TAP_SLOW, TAP_MID, TAP_FAST);
    localparam int TAP_K [NUM_TAPS] = '{TAP_SLOW, TAP_MID, TAP_FAST};

    logic [PRE_W-1:0]    pre_q;
    logic [NUM_TAPS-1:0] tap_pulse;

    always_ff @(posedge clk) begin
        if (rst) pre_q <= '0;
        else     pre_q <= pre_q + PRE_W'(1);
    end

    // A tap fires once every 2^k cycles, when its low k bits are all ones
    for (genvar g = 0; g < NUM_TAPS; g++) begin : g_tap
        assign tap_pulse[g] = &pre_q[TAP_K[g]-1:0];
    end

    always_comb begin
        int idx;
        idx  = sel_to_tap(sel);
        en_o = 1'b0;
        for (int t = 0; t < NUM_TAPS; t++) begin
            if (idx == t) en_o = tap_pulse[t];
        end
    end

endmodule

// File: rtl/pdo_match_counter.sv
module pdo_match_counter
    import pdo_pkg::*;
#(
    parameter int              CNT_W   = 8,
    parameter logic [CNT_W-1:0] CMP_RST = '1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             en,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    output cnt_evt_t         evt_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cmp_q;
    logic             step;

    assign step      = run & en;
    assign evt_o.en  = step;
    assign evt_o.hit = step & (cnt_q == cmp_q);

    always_ff @(posedge clk) begin
        if (rst)         cmp_q <= CMP_RST;
        else if (cmp_wr) cmp_q <= cmp_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || !run)    cnt_q <= '0;
        else if (evt_o.hit) cnt_q <= '0;
        else if (step)      cnt_q <= cnt_q + CNT_W'(1);
    end

endmodule

// File: rtl/pdo_toggle_ff.sv
module pdo_toggle_ff
    import pdo_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  cnt_evt_t evt,
    input  logic     ff_wr,
    input  logic     ff_wdata,
    output logic     ff_q,
    output logic     irq_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            ff_q  <= 1'b0;
            irq_q <= 1'b0;
        end else if (ff_wr) begin
            ff_q  <= ff_wdata;
            irq_q <= 1'b0;
        end else if (evt.hit) begin
            ff_q  <= ~ff_q;
            irq_q <= 1'b1;
        end else begin
            irq_q <= 1'b0;
        end
    end

endmodule

// File: rtl/pdo_pulse_timer.sv
module pdo_pulse_timer
    import pdo_pkg::*;
#(
    parameter int CNT_W    = 8,
    parameter int TAP_SLOW = 11,
    parameter int TAP_MID  = 7,
    parameter int TAP_FAST = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       clk_sel,
    input  logic             run,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_wdata,
    input  logic             ff_wr,
    input  logic             ff_wdata,
    output logic             pin_out,
    output logic             irq
);
    logic     cnt_en;
    cnt_evt_t evt;
    logic     ff_q;

    pdo_prescaler #(
        .TAP_SLOW (TAP_SLOW),
        .TAP_MID  (TAP_MID),
        .TAP_FAST (TAP_FAST)
    ) u_pre (
        .clk  (clk),
        .rst  (rst),
        .sel  (clk_sel_e'(clk_sel)),
        .en_o (cnt_en)
    );

    pdo_match_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .run       (run),
        .en        (cnt_en),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .evt_o     (evt)
    );

    pdo_toggle_ff u_ff (
        .clk      (clk),
        .rst      (rst),
        .evt      (evt),
        .ff_wr    (ff_wr),
        .ff_wdata (ff_wdata),
        .ff_q     (ff_q),
        .irq_q    (irq)
    );

    assign pin_out = ~ff_q;

endmodule

// File: rtl/pdo_pulse_timer_chk.sv
module pdo_pulse_timer_chk (
    input logic       clk,
    input logic       rst,
    input logic [1:0] clk_sel,
    input logic       run,
    input logic       ff_wr,
    input logic       ff_wdata,
    input logic       pin_out,
    input logic       irq
);
    // R4: strobe lasts one cycle
    p_irq_single_r4: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R3: a strobe always comes with a pin change
    p_irq_flips_pin_r3: assert property (@(posedge clk) disable iff (rst)
        (irq && !$past(rst)) |-> (pin_out != $past(pin_out)));

    // R3: a pin change not caused by a write comes with a strobe
    p_pin_change_irq_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(ff_wr) && !$stable(pin_out)) |-> irq);

    // R6: stopped select gives no strobe
    p_stopped_sel_r6: assert property (@(posedge clk) disable iff (rst)
        ($past(clk_sel) == 2'b11) |-> !irq);

    // R7: no strobe while run is low
    p_run_low_r7: assert property (@(posedge clk) disable iff (rst)
        !$past(run) |-> !irq);

    // R8: a write sets the pin and raises no strobe
    p_write_r8: assert property (@(posedge clk) disable iff (rst)
        ($past(ff_wr) && !$past(rst)) |-> ((pin_out == !$past(ff_wdata)) && !irq));

endmodule

bind pdo_pulse_timer pdo_pulse_timer_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .clk_sel  (clk_sel),
    .run      (run),
    .ff_wr    (ff_wr),
    .ff_wdata (ff_wdata),
    .pin_out  (pin_out),
    .irq      (irq)
);

// File: tb/pdo_pulse_timer_tb.sv
module pdo_pulse_timer_tb;

    localparam int K_SLOW = 6;
    localparam int K_MID  = 4;
    localparam int K_FAST = 2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] clk_sel = 2'b00;
    logic       run = 1'b0;
    logic       cmp_wr = 1'b0;
    logic [7:0] cmp_wdata = 8'h00;
    logic       ff_wr = 1'b0;
    logic       ff_wdata = 1'b0;
    logic       pin_out;
    logic       irq;

    typedef struct {
        int    lo;
        int    hi;
        bit    pin;
        string tag;
    } exp_t;

    exp_t q[$];
    int   cyc = 0;
    int   mark = 0;
    int   n_chk = 0;
    int   n_fail = 0;
    bit   mflop = 1'b0;
    bit   prev_irq = 1'b0;
    bit   done = 1'b0;

    always #2.5 clk = ~clk;

    pdo_pulse_timer #(
        .CNT_W    (8),
        .TAP_SLOW (K_SLOW),
        .TAP_MID  (K_MID),
        .TAP_FAST (K_FAST)
    ) u_dut (
        .clk       (clk),
        .rst       (rst),
        .clk_sel   (clk_sel),
        .run       (run),
        .cmp_wr    (cmp_wr),
        .cmp_wdata (cmp_wdata),
        .ff_wr     (ff_wr),
        .ff_wdata  (ff_wdata),
        .pin_out   (pin_out),
        .irq       (irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(posedge clk) cyc++;

    // Monitor: every strobe pops and checks one expected toggle
    always @(negedge clk) begin
        if (!rst) begin
            if (irq) begin
                chk(!prev_irq, "R4", int'(prev_irq), 0);
                if (q.size() == 0) begin
                    chk(1'b0, "R6/R7/R8 unexpected irq", 1, 0);
                end else begin
                    exp_t e;
                    int   d;
                    e = q.pop_front();
                    d = cyc - mark;
                    chk(pin_out == e.pin, "R3", int'(pin_out), int'(e.pin));
                    chk(d >= e.lo && d <= e.hi, e.tag, d, e.hi);
                end
                mark = cyc;
            end
            prev_irq = irq;
        end
    end

    task automatic write_cmp(input logic [7:0] v);
        @(negedge clk);
        cmp_wr = 1'b1;
        cmp_wdata = v;
        @(negedge clk);
        cmp_wr = 1'b0;
    endtask

    // Driver: start a run and queue n expected toggles
    task automatic do_run(input logic [1:0] sel, input int cmpv, input int k,
                          input int n, input string tag, input bit keep);
        int per;
        per = (cmpv + 1) << k;
        write_cmp(8'(cmpv));
        clk_sel = sel;
        @(negedge clk);
        run = 1'b1;
        mark = cyc;
        for (int i = 0; i < n; i++) begin
            exp_t e;
            mflop = ~mflop;
            e.pin = ~mflop;
            if (i == 0) begin
                e.lo = (cmpv << k) + 1;
                e.hi = per;
                e.tag = "R7 first toggle";
            end else begin
                e.lo = per;
                e.hi = per;
                e.tag = tag;
            end
            q.push_back(e);
        end
        wait (q.size() == 0);
        if (!keep) begin
            @(negedge clk);
            run = 1'b0;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        chk(pin_out == 1'b1, "R1 pin", int'(pin_out), 1);
        chk(irq == 1'b0, "R1 irq", int'(irq), 0);

        // R2: spacing for each tap
        do_run(2'b00, 2, K_SLOW, 3, "R2 slow tap", 1'b0);
        do_run(2'b01, 5, K_MID, 3, "R2 mid tap", 1'b0);
        do_run(2'b10, 8'h5F, K_FAST, 3, "R2 fast tap 0x5F", 1'b0);

        // R7: run low holds everything
        repeat (200) @(negedge clk);
        chk(pin_out == ~mflop, "R7 idle pin", int'(pin_out), int'(~mflop));

        // R5: compare 0 toggles every count period
        do_run(2'b10, 0, K_FAST, 4, "R5 compare zero", 1'b0);

        // R6: stopped select with run high
        clk_sel = 2'b11;
        @(negedge clk);
        run = 1'b1;
        repeat (300) @(negedge clk);
        chk(pin_out == ~mflop, "R6 stopped pin", int'(pin_out), int'(~mflop));
        run = 1'b0;
        @(negedge clk);

        // R8: plain writes
        ff_wr = 1'b1;
        ff_wdata = ~mflop;
        @(negedge clk);
        ff_wr = 1'b0;
        mflop = ~mflop;
        chk(pin_out == ~mflop, "R8 write pin", int'(pin_out), int'(~mflop));
        chk(irq == 1'b0, "R8 write irq", int'(irq), 0);
        @(negedge clk);
        ff_wr = 1'b1;
        ff_wdata = ~mflop;
        @(negedge clk);
        ff_wr = 1'b0;
        mflop = ~mflop;
        chk(pin_out == ~mflop, "R8 second write pin", int'(pin_out), int'(~mflop));

        // R8: write on the same edge as a toggle
        do_run(2'b10, 0, K_FAST, 3, "R5 compare zero", 1'b1);
        repeat (3) @(negedge clk);
        ff_wr = 1'b1;
        ff_wdata = mflop;
        @(negedge clk);
        ff_wr = 1'b0;
        chk(pin_out == ~mflop, "R8 collision pin", int'(pin_out), int'(~mflop));
        chk(irq == 1'b0, "R8 collision irq", int'(irq), 0);
        mark = cyc;
        begin
            exp_t e;
            mflop = ~mflop;
            e.pin = ~mflop;
            e.lo = 1 << K_FAST;
            e.hi = 1 << K_FAST;
            e.tag = "R8 counter cleared after collision";
            q.push_back(e);
        end
        wait (q.size() == 0);
        @(negedge clk);
        run = 1'b0;
        repeat (50) @(negedge clk);
        chk(q.size() == 0, "R7 queue drained", q.size(), 0);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule